// File: doc/BRIEF.md
# Compare-Swap-Then-Store Sequencer

This block carries out one conditional-update operation on memory. It takes a control word, a compare value held in one or two 64-bit registers, a swap address, a store address and a parameter-list address. It checks the operands. It then reads the parameter list and the current contents at the swap address. It writes back either the new value or the unchanged old value, and only when the compare matched does it write a separately sized value to the store address. The result is a condition code and the old value, laid out in the compare-register image.

The block talks to a synchronous, doubleword-wide, big-endian memory through one request port with byte enables and a one-cycle read latency. A caller pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse, at which point `cc`, `spec_exc`, `res_hi` and `res_lo` are valid.

Top module: `cswst_unit`

## Requirements
- R1: The swap kind comes from bits 7:0 of `ctrl_word`: codes 0, 1 and 2 swap 4, 8 and 16 bytes. The store kind comes from bits 15:8: codes 0 to 4 store 1, 2, 4, 8 and 16 bytes.
- R2: With `ext_en` low, a swap code above 1 or a store code above 3 is a specification exception. With `ext_en` high, the limits are 2 and 4.
- R3: Swap code 2 together with `cmp_reg_odd` high is a specification exception.
- R4: A swap address not aligned to the swap size, or a store address not aligned to the store size, is a specification exception. On any exception no memory request is made, `done` rises one cycle after `start`, `cc` is 0 and `res_hi`/`res_lo` echo `cmp_hi`/`cmp_lo`.
- R5: The parameter-list address has its low 4 bits cleared. The new swap value is read from offset 0 (and offset 8 for a 16-byte swap), and the store value is read from offsets 16 and 24.
- R6: Every read of the operation is issued before its first write.
- R7: The compare value is `cmp_hi[31:0]` for 4 bytes, `cmp_hi` for 8 bytes, and `{cmp_hi,cmp_lo}` for 16 bytes. If the old value equals it, the new value is written and `cc` is 0. Otherwise the old value is written back and `cc` is 1.
- R8: The store happens only when `cc` is 0. A store of under 8 bytes takes its bytes from the most significant end of the doubleword at parameter offset 16.
- R9: For a 4-byte swap, `res_hi` is `{old, cmp_hi[31:0]}` and `res_lo` is `cmp_lo`. For 8 bytes, `res_hi` is the old value and `res_lo` is `cmp_lo`. For 16 bytes, `res_hi` and `res_lo` are the old high and low doublewords.
- R10: `done` is high for exactly one cycle and `busy` is low while it is high. `start` is only taken while idle. A valid operation raises `done` R+2+W clock edges after the edge that takes `start`, counting that edge. Here R is 4 reads (6 for a 16-byte swap) and W is the number of write beats.
- R11: Memory addresses are doubleword aligned. `mem_be[7]` is the byte at the lowest address, with data in bits 63:56. A 16-byte access is two beats, the high doubleword first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| ctrl_word | input | 16 | Swap code [7:0], store code [15:8] |
| ext_en | input | 1 | Enables the wider swap and store codes |
| cmp_reg_odd | input | 1 | Compare register number is odd |
| cmp_hi | input | 64 | Even compare register |
| cmp_lo | input | 64 | Odd compare register |
| swap_addr | input | AW | Byte address of the swap operand |
| store_addr | input | AW | Byte address of the store operand |
| plist_addr | input | AW | Byte address of the parameter list |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Doubleword-aligned byte address |
| mem_wdata | output | 64 | Write data, big-endian lanes |
| mem_be | output | 8 | Byte enables, bit 7 = lowest address |
| mem_rdata | input | 64 | Read data, one cycle after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 1 | Condition code: 0 match, 1 mismatch |
| spec_exc | output | 1 | Specification exception |
| res_hi | output | 64 | Updated even register image |
| res_lo | output | 64 | Updated odd register image |

## Verification
An exception is reported at the first clock edge after the edge that takes `start`. A valid operation takes four or six read cycles, one capture cycle, and then one cycle per write beat. Those write beats are the swap (one or two) plus the store (zero, one or two, depending on the compare result). The bench drives on the falling edge and counts falling edges until `done`. It requires that count to equal the latency it predicts from the codes and its own compare outcome. `cc`, the exception flag and both result words are sampled in that same `done` cycle. The memory image is compared with a byte-level reference straight afterwards.

// File: rtl/cswst_pkg.sv
package cswst_pkg;
    localparam int DW    = 64;
    localparam int DBYTES = DW / 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WAIT,
        PH_SWAP_HI,
        PH_SWAP_LO,
        PH_STORE_HI,
        PH_STORE_LO
    } phase_e;

    // read beat numbering
    localparam logic [2:0] BT_NEW_HI = 3'd0;
    localparam logic [2:0] BT_NEW_LO = 3'd1;
    localparam logic [2:0] BT_SV_HI  = 3'd2;
    localparam logic [2:0] BT_SV_LO  = 3'd3;
    localparam logic [2:0] BT_OLD_HI = 3'd4;
    localparam logic [2:0] BT_OLD_LO = 3'd5;
endpackage

// File: rtl/cswst_check.sv
module cswst_check #(
    parameter int AW = 16
) (
    input  logic [7:0]    fc,
    input  logic [7:0]    sc,
    input  logic          ext_en,
    input  logic          reg_odd,
    input  logic [AW-1:0] swap_addr,
    input  logic [AW-1:0] store_addr,
    output logic          bad
);
    logic       codes_ok;
    logic       pair_bad;
    logic [3:0] swap_mask;
    logic [3:0] store_mask;
    logic       misaligned;

    always_comb begin
        codes_ok = ext_en ? (fc <= 8'd2 && sc <= 8'd4) : (fc <= 8'd1 && sc <= 8'd3);
        pair_bad = (fc == 8'd2) && reg_odd;
        case (fc[1:0])
            2'd0:    swap_mask = 4'h3;
            2'd1:    swap_mask = 4'h7;
            default: swap_mask = 4'hF;
        endcase
        case (sc[2:0])
            3'd0:    store_mask = 4'h0;
            3'd1:    store_mask = 4'h1;
            3'd2:    store_mask = 4'h3;
            3'd3:    store_mask = 4'h7;
            default: store_mask = 4'hF;
        endcase
        misaligned = (|(swap_addr[3:0] & swap_mask)) || (|(store_addr[3:0] & store_mask));
        bad = !codes_ok || pair_bad || misaligned;
    end
endmodule

// File: rtl/cswst_lane.sv
module cswst_lane (
    input  logic [1:0]  size_log2,
    input  logic [2:0]  offset,
    input  logic [63:0] value,
    output logic [63:0] wdata,
    output logic [7:0]  be
);
    logic [7:0] base;

    always_comb begin
        case (size_log2)
            2'd0:    base = 8'h80;
            2'd1:    base = 8'hC0;
            2'd2:    base = 8'hF0;
            default: base = 8'hFF;
        endcase
        be    = base >> offset;
        wdata = value >> {offset, 3'b000};
    end
endmodule

// File: rtl/cswst_unit.sv
module cswst_unit #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   ctrl_word,
    input  logic          ext_en,
    input  logic          cmp_reg_odd,
    input  logic [63:0]   cmp_hi,
    input  logic [63:0]   cmp_lo,
    input  logic [AW-1:0] swap_addr,
    input  logic [AW-1:0] store_addr,
    input  logic [AW-1:0] plist_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    output logic [7:0]    mem_be,
    input  logic [63:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          cc,
    output logic          spec_exc,
    output logic [63:0]   res_hi,
    output logic [63:0]   res_lo
);
    import cswst_pkg::*;

    localparam logic [AW-1:0] STEP     = AW'(DBYTES);
    localparam logic [AW-1:0] DW_MASK  = ~AW'(DBYTES - 1);
    localparam logic [AW-1:0] PL_MASK  = ~AW'(2 * DBYTES - 1);

    typedef struct packed {
        phase_e        ph;
        logic [2:0]    idx;
        logic          rd_pend;
        logic [2:0]    rd_idx;
        logic [1:0]    fc;
        logic [2:0]    sc;
        logic [AW-1:0] a1;
        logic [AW-1:0] a2;
        logic [AW-1:0] pl;
        logic [63:0]   cmp_hi;
        logic [63:0]   cmp_lo;
        logic [63:0]   nv_hi;
        logic [63:0]   nv_lo;
        logic [63:0]   sv_hi;
        logic [63:0]   sv_lo;
        logic [63:0]   old_hi;
        logic [63:0]   old_lo;
        logic          cc;
        logic          exc;
        logic          done;
        logic [63:0]   res_hi;
        logic [63:0]   res_lo;
    } state_t;

    state_t s_q, s_d;

    logic          chk_bad;
    logic [1:0]    lane_size;
    logic [2:0]    lane_off;
    logic [63:0]   lane_val;
    logic [63:0]   lane_wdata;
    logic [7:0]    lane_be;
    logic [31:0]   old32;
    logic          hit;
    logic          wide;
    logic          last_beat;
    logic [AW-1:0] a1_dw;
    logic [AW-1:0] a2_dw;
    logic [AW-1:0] beat_addr;

    cswst_check #(.AW(AW)) u_check (
        .fc        (ctrl_word[7:0]),
        .sc        (ctrl_word[15:8]),
        .ext_en    (ext_en),
        .reg_odd   (cmp_reg_odd),
        .swap_addr (swap_addr),
        .store_addr(store_addr),
        .bad       (chk_bad)
    );

    cswst_lane u_lane (
        .size_log2(lane_size),
        .offset   (lane_off),
        .value    (lane_val),
        .wdata    (lane_wdata),
        .be       (lane_be)
    );

    always_comb begin
        wide   = (s_q.fc == 2'd2);
        a1_dw  = s_q.a1 & DW_MASK;
        a2_dw  = s_q.a2 & DW_MASK;
        old32  = s_q.a1[2] ? s_q.old_hi[31:0] : s_q.old_hi[63:32];
        case (s_q.fc)
            2'd0:    hit = (old32 == s_q.cmp_hi[31:0]);
            2'd1:    hit = (s_q.old_hi == s_q.cmp_hi);
            default: hit = (s_q.old_hi == s_q.cmp_hi) && (s_q.old_lo == s_q.cmp_lo);
        endcase
        last_beat = (s_q.idx == BT_OLD_LO) || (s_q.idx == BT_OLD_HI && !wide);
        case (s_q.idx)
            BT_NEW_HI: beat_addr = s_q.pl;
            BT_NEW_LO: beat_addr = s_q.pl + STEP;
            BT_SV_HI:  beat_addr = s_q.pl + 2 * STEP;
            BT_SV_LO:  beat_addr = s_q.pl + 3 * STEP;
            BT_OLD_HI: beat_addr = a1_dw;
            default:   beat_addr = a1_dw + STEP;
        endcase

        s_d       = s_q;
        s_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        lane_size = 2'd3;
        lane_off  = 3'd0;
        lane_val  = '0;

        // capture read data one cycle after its request
        s_d.rd_pend = 1'b0;
        if (s_q.rd_pend) begin
            case (s_q.rd_idx)
                BT_NEW_HI: s_d.nv_hi  = mem_rdata;
                BT_NEW_LO: s_d.nv_lo  = mem_rdata;
                BT_SV_HI:  s_d.sv_hi  = mem_rdata;
                BT_SV_LO:  s_d.sv_lo  = mem_rdata;
                BT_OLD_HI: s_d.old_hi = mem_rdata;
                default:   s_d.old_lo = mem_rdata;
            endcase
        end

        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.fc     = ctrl_word[1:0];
                    s_d.sc     = ctrl_word[10:8];
                    s_d.a1     = swap_addr;
                    s_d.a2     = store_addr;
                    s_d.pl     = plist_addr & PL_MASK;
                    s_d.cmp_hi = cmp_hi;
                    s_d.cmp_lo = cmp_lo;
                    s_d.res_hi = cmp_hi;
                    s_d.res_lo = cmp_lo;
                    s_d.cc     = 1'b0;
                    s_d.idx    = BT_NEW_HI;
                    if (chk_bad) begin
                        s_d.exc  = 1'b1;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.exc = 1'b0;
                        s_d.ph  = PH_READ;
                    end
                end
            end
            PH_READ: begin
                mem_req     = 1'b1;
                mem_addr    = beat_addr;
                s_d.rd_pend = 1'b1;
                s_d.rd_idx  = s_q.idx;
                if (last_beat) begin
                    s_d.ph = PH_WAIT;
                end else if (s_q.idx == BT_NEW_HI && !wide) begin
                    s_d.idx = BT_SV_HI;
                end else begin
                    s_d.idx = s_q.idx + 3'd1;
                end
            end
            PH_WAIT: begin
                s_d.ph = PH_SWAP_HI;
            end
            PH_SWAP_HI: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = a1_dw;
                s_d.cc   = !hit;
                if (s_q.fc == 2'd0) begin
                    lane_size  = 2'd2;
                    lane_off   = s_q.a1[2:0];
                    lane_val   = {hit ? s_q.nv_hi[63:32] : old32, 32'h0};
                    s_d.res_hi = {old32, s_q.cmp_hi[31:0]};
                end else begin
                    lane_val   = hit ? s_q.nv_hi : s_q.old_hi;
                    s_d.res_hi = s_q.old_hi;
                    if (wide) s_d.res_lo = s_q.old_lo;
                end
                if (wide) begin
                    s_d.ph = PH_SWAP_LO;
                end else if (hit) begin
                    s_d.ph = PH_STORE_HI;
                end else begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            end
            PH_SWAP_LO: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = a1_dw + STEP;
                lane_val = s_q.cc ? s_q.old_lo : s_q.nv_lo;
                if (!s_q.cc) begin
                    s_d.ph = PH_STORE_HI;
                end else begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            end
            PH_STORE_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = a2_dw;
                lane_size = (s_q.sc >= 3'd3) ? 2'd3 : s_q.sc[1:0];
                lane_off  = s_q.a2[2:0];
                lane_val  = s_q.sv_hi;
                if (s_q.sc == 3'd4) begin
                    s_d.ph = PH_STORE_LO;
                end else begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            end
            PH_STORE_LO: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = a2_dw + STEP;
                lane_val = s_q.sv_lo;
                s_d.ph   = PH_IDLE;
                s_d.done = 1'b1;
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase

        mem_wdata = mem_we ? lane_wdata : 64'h0;
        mem_be    = mem_we ? lane_be : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.ph != PH_IDLE);
    assign done     = s_q.done;
    assign cc       = s_q.cc;
    assign spec_exc = s_q.exc;
    assign res_hi   = s_q.res_hi;
    assign res_lo   = s_q.res_lo;
endmodule

// File: rtl/cswst_unit_sva.sv
module cswst_unit_sva #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          cc,
    input logic          spec_exc,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_be
);
    logic wrote_q;
    logic touched_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_q   <= 1'b0;
            touched_q <= 1'b0;
        end else if (done) begin
            wrote_q   <= 1'b0;
            touched_q <= 1'b0;
        end else begin
            if (mem_req && mem_we) wrote_q <= 1'b1;
            if (mem_req) touched_q <= 1'b1;
        end
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    a_r6_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !wrote_q);
    a_r4_exc_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (done && spec_exc) |-> !touched_q);
    a_r4_exc_cc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && spec_exc) |-> !cc);
    a_r11_dw_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));
    a_r11_be_present: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 8'h00));
endmodule

bind cswst_unit cswst_unit_sva #(.AW(AW)) u_sva (.*);

// File: tb/cswst_unit_tb_top.sv
`timescale 1ns/1ps
module cswst_unit_tb_top;
    localparam int AW = 16;
    localparam int MB = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   ctrl_word = '0;
    logic          ext_en = 1'b0;
    logic          cmp_reg_odd = 1'b0;
    logic [63:0]   cmp_hi = '0;
    logic [63:0]   cmp_lo = '0;
    logic [AW-1:0] swap_addr = '0;
    logic [AW-1:0] store_addr = '0;
    logic [AW-1:0] plist_addr = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [7:0]    mem_be;
    logic [63:0]   mem_rdata;
    logic          busy, done, cc, spec_exc;
    logic [63:0]   res_hi, res_lo;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] dmem [MB/8];
    logic [7:0]  rb [MB];

    always #2.5 clk = ~clk;

    cswst_unit #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
        .ext_en(ext_en), .cmp_reg_odd(cmp_reg_odd), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .swap_addr(swap_addr), .store_addr(store_addr), .plist_addr(plist_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .busy(busy), .done(done), .cc(cc),
        .spec_exc(spec_exc), .res_hi(res_hi), .res_lo(res_lo)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[7-b]) dmem[mem_addr[8:3]][63-8*b -: 8] <= mem_wdata[63-8*b -: 8];
            end else begin
                mem_rdata <= dmem[mem_addr[8:3]];
            end
        end
    end

    task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rd_bytes(input int a, input int n);
        logic [127:0] v = '0;
        for (int i = 0; i < n; i++) v = (v << 8) | 128'(rb[a+i]);
        return v;
    endfunction

    task automatic wr_bytes(input int a, input int n, input logic [127:0] v);
        for (int i = 0; i < n; i++) rb[a+i] = v[(n-1-i)*8 +: 8];
    endtask

    function automatic logic ref_bad(input int fc, input int sc, input logic ext, input logic odd,
                                     input int a1, input int a2);
        if (ext ? (fc > 2 || sc > 4) : (fc > 1 || sc > 3)) return 1'b1;
        if (fc == 2 && odd) return 1'b1;
        if ((a1 % (4 << fc)) != 0 || (a2 % (1 << sc)) != 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic run_op(input int fc, input int sc, input logic ext, input logic odd,
                          input logic [63:0] ch, input logic [63:0] cl,
                          input int a1, input int a2, input int pl, input string tag);
        logic         e_exc, e_cc, hitv;
        logic [63:0]  e_hi, e_lo;
        logic [127:0] nv, sv, oldv, cv;
        int nb, sb, p, e_n, n;
        bit mem_ok;
        e_exc = ref_bad(fc, sc, ext, odd, a1, a2);
        e_cc = 1'b0; e_hi = ch; e_lo = cl; e_n = 1;
        if (!e_exc) begin
            nb = 4 << fc; sb = 1 << sc; p = pl & ~15;
            nv = rd_bytes(p, nb);
            sv = rd_bytes(p + 16, sb);
            oldv = rd_bytes(a1, nb);
            cv = (fc == 0) ? 128'(ch[31:0]) : (fc == 1) ? 128'(ch) : {ch, cl};
            hitv = (oldv == cv);
            wr_bytes(a1, nb, hitv ? nv : oldv);
            if (hitv) wr_bytes(a2, sb, sv);
            e_cc = !hitv;
            if (fc == 0) e_hi = {oldv[31:0], ch[31:0]};
            else if (fc == 1) e_hi = oldv[63:0];
            else begin e_hi = oldv[127:64]; e_lo = oldv[63:0]; end
            e_n = ((fc == 2) ? 6 : 4) + 2 + ((fc == 2) ? 2 : 1) + (hitv ? ((sc == 4) ? 2 : 1) : 0);
        end
        ctrl_word = {8'(sc), 8'(fc)};
        ext_en = ext; cmp_reg_odd = odd; cmp_hi = ch; cmp_lo = cl;
        swap_addr = AW'(a1); store_addr = AW'(a2); plist_addr = AW'(pl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 100) begin @(negedge clk); n++; end
        check(n == e_n, {"R10 latency ", tag}, 128'(n), 128'(e_n));
        check(spec_exc == e_exc, {"R2 R3 R4 exception ", tag}, 128'(spec_exc), 128'(e_exc));
        check(cc == e_cc, {"R7 cc ", tag}, 128'(cc), 128'(e_cc));
        check(res_hi == e_hi, {"R9 res_hi ", tag}, 128'(res_hi), 128'(e_hi));
        check(res_lo == e_lo, {"R9 res_lo ", tag}, 128'(res_lo), 128'(e_lo));
        mem_ok = 1'b1;
        for (int i = 0; i < MB/8; i++)
            if (dmem[i] != rd_bytes(i*8, 8)) begin
                mem_ok = 1'b0;
                check(1'b0, {"R5 R8 R11 memory ", tag}, 128'(dmem[i]), rd_bytes(i*8, 8));
                break;
            end
        if (mem_ok) check(1'b1, "R8 memory", 0, 0);
        @(negedge clk);
    endtask

    task automatic rand_op(input int fc, input int sc, input logic ext, input logic odd,
                           input bit want_hit, input int mis1, input int mis2, input string tag);
        int a1, a2, pl, nb;
        logic [127:0] o;
        logic [63:0] ch, cl;
        pl = int'($urandom % 30) * 16 + int'($urandom % 16);
        a1 = int'($urandom % 30) * 16 + mis1;
        a2 = int'($urandom % 30) * 16 + mis2;
        if (fc <= 1) a1 += int'($urandom % 4) * ((fc == 0) ? 4 : 8) % 16;
        if (sc <= 3) a2 += (int'($urandom % 16) & ~((1 << sc) - 1)) & 15;
        ch = {$urandom, $urandom}; cl = {$urandom, $urandom};
        nb = (fc <= 2) ? (4 << fc) : 16;
        if (want_hit) begin
            o = rd_bytes(a1, nb);
            if (fc == 0) ch[31:0] = o[31:0];
            else if (fc == 1) ch = o[63:0];
            else begin ch = o[127:64]; cl = o[63:0]; end
        end
        run_op(fc, sc, ext, odd, ch, cl, a1, a2, pl, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < MB; i++) rb[i] = 8'($urandom);
        for (int i = 0; i < MB/8; i++) dmem[i] = rd_bytes(i*8, 8);
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R10 reset idle", {busy, done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R7 R8: every swap/store code pair, hit and miss
        for (int f = 0; f < 3; f++)
            for (int s = 0; s < 5; s++)
                for (int h = 0; h < 2; h++)
                    rand_op(f, s, 1'b1, 1'b0, h == 1, 0, 0, "R1 sweep");

        // R2 facility gating
        rand_op(2, 0, 1'b0, 1'b0, 1, 0, 0, "R2 fc2 gated");
        rand_op(0, 4, 1'b0, 1'b0, 1, 0, 0, "R2 sc4 gated");
        rand_op(3, 0, 1'b1, 1'b0, 1, 0, 0, "R2 fc3");
        rand_op(1, 5, 1'b1, 1'b0, 1, 0, 0, "R2 sc5");
        rand_op(1, 3, 1'b0, 1'b0, 1, 0, 0, "R2 base ok");
        // R3 odd pair
        rand_op(2, 3, 1'b1, 1'b1, 1, 0, 0, "R3 odd pair");
        rand_op(1, 3, 1'b1, 1'b1, 1, 0, 0, "R3 odd fc1 ok");
        // R4 misalignment of each operand
        rand_op(0, 0, 1'b1, 1'b0, 1, 2, 0, "R4 swap4 mis");
        rand_op(1, 0, 1'b1, 1'b0, 1, 4, 0, "R4 swap8 mis");
        rand_op(2, 0, 1'b1, 1'b0, 1, 8, 0, "R4 swap16 mis");
        rand_op(1, 1, 1'b1, 1'b0, 1, 0, 1, "R4 store2 mis");
        rand_op(1, 3, 1'b1, 1'b0, 1, 0, 4, "R4 store8 mis");
        rand_op(1, 4, 1'b1, 1'b0, 1, 0, 8, "R4 store16 mis");

        // constrained random mix
        for (int k = 0; k < 250; k++) begin
            int f, s, m1, m2;
            f = int'($urandom % 4); s = int'($urandom % 6);
            m1 = ($urandom % 5 == 0) ? int'(1 + $urandom % 3) : 0;
            m2 = ($urandom % 5 == 0) ? int'(1 + $urandom % 3) : 0;
            rand_op(f, s, 1'($urandom % 4 != 0), 1'($urandom % 4 == 0),
                    ($urandom % 2) == 1, m1, m2, "R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule